// File: doc/BRIEF.md
# Streaming Fold-and-Butterfly Stage

This block is one stage of a pipelined fast cosine transform. It takes a continuous stream of signed samples, one word per accepted clock. The words form frames of `FRAME_LEN` samples that follow each other with no gap. For every frame it produces `FRAME_LEN/2` folded sums and then `FRAME_LEN/2` folded differences. Each sum pairs a sample from the first half, taken from the middle outward, with the mirrored sample from the second half. Each difference is scaled by a cosine twiddle factor before it leaves.

The stage has no serial-to-parallel converter. The first half of a frame goes into a shift buffer that can shift in either direction. When the second half arrives, the buffer pops the first half back out in reverse order, and the sums are formed on the fly. The popped words are also copied into a second shift buffer that only shifts one way. The differences are formed in the next half-frame, while the first half of the following frame loads. One adder/subtractor does both jobs, and one flag tells which result is on the output.

`in_valid` qualifies every input word. A cycle with `in_valid` low freezes the stage. The differences of a frame are released by the first-half samples of the frame after it.

Top module: `fold_butterfly_stage`

## Requirements
- R1: While reset is asserted, and after it is released until the first result, `out_valid` is 0 and `out_data` is 0.
- R2: Let H = FRAME_LEN/2 and let the frame be x(0..FRAME_LEN-1). One clock after the word x(H+j) is accepted (j = 0..H-1), the block shows `out_valid`=1, `out_is_sum`=1 and `out_data` = x(H-1-j)+x(H+j). The sum is full precision in DATA_W+1 bits.
- R3: One clock after sample j of the next frame's first half is accepted, the block shows `out_valid`=1, `out_is_sum`=0 and `out_data` = floor((d·C(n) + 2^13) / 2^14). Here d = x(n)-x(H+j) with n = H-1-j, and C(n) = floor(cos((2n+1)π/(2·FRAME_LEN))·2^14 + 0.5) is the signed Q1.14 twiddle.
- R4: After reset, the first H accepted words produce no output. The first result appears one clock after the (H+1)-th accepted word.
- R5: Within each half-frame, results come out in ascending j, with one result per accepted word.
- R6: A clock with `in_valid` low gives `out_valid`=0 on the next clock and changes no stored state. A stream with idle gaps gives the same results as the same stream without gaps.
- R7: Frames that follow each other with no idle cycle keep producing correct sums and differences for at least four frames in a row. This covers frames whose buffer shifts in either direction.
- R8: Full-scale inputs do not wrap. Two samples of +32767 sum to 65534, and differences of full-scale operands are scaled without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_data`; low stalls the stage |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | A result is present on `out_data` |
| out_data | output | DATA_W+1 | Signed sum or scaled difference |
| out_is_sum | output | 1 | 1 = folded sum, 0 = scaled difference |

## Verification
The main risk is the bidirectional buffer, whose shift direction must flip at the start of every second half-frame. A design that fixed the direction would pair the wrong words from the second frame onward, so four frames are streamed back to back. The twiddle ROM must be read in the reverse order of the differences; a forward-indexed ROM produces wrong values only in the difference slots, and those are compared word by word. Idle gaps are inserted in the middle of a frame, where a design that advanced on every clock would emit extra results or misalign the halves. A reset in the middle of a frame and a full-scale frame check the silent first half and the guard bit of the adder.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;
endpackage

// File: rtl/fold_seq_ctrl.sv
module fold_seq_ctrl
  import fold_pkg::*;
#(
  parameter int HALF = 4,
  parameter int IW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output half_e         half_q,
  output logic [IW-1:0] idx_q,
  output logic          primed_q,
  output logic          dir_up_q
);
  half_e         half_d;
  logic [IW-1:0] idx_d;
  logic          primed_d;
  logic          dir_d;
  logic          wrap;

  assign wrap = (idx_q == IW'(HALF - 1));

  always_comb begin
    half_d   = half_q;
    idx_d    = idx_q;
    primed_d = primed_q;
    dir_d    = dir_up_q;
    if (in_valid) begin
      idx_d = wrap ? '0 : idx_q + IW'(1);
      if (wrap) begin
        half_d = (half_q == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
        if (half_q == HALF_FIRST) dir_d = ~dir_up_q;
        else                      primed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= HALF_FIRST;
      idx_q    <= '0;
      primed_q <= 1'b0;
      dir_up_q <= 1'b1;
    end else begin
      half_q   <= half_d;
      idx_q    <= idx_d;
      primed_q <= primed_d;
      dir_up_q <= dir_d;
    end
  end

  // R6: idle cycles leave the sequencing state untouched
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(idx_q) && $stable(half_q) && $stable(dir_up_q)));

  // R7: entering a pairing half-frame reverses the buffer direction
  a_r7_dir_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && half_q == HALF_FIRST && wrap) |=>
      (half_q == HALF_SECOND && dir_up_q != $past(dir_up_q)));
endmodule

// File: rtl/fold_bidir_buf.sv
module fold_bidir_buf #(
  parameter int HALF = 4,
  parameter int W    = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         dir_up,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] cell_q [HALF];
  logic [W-1:0] cell_d [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_cell
    logic [W-1:0] from_below;
    logic [W-1:0] from_above;
    if (k == 0) begin : g_bot
      assign from_below = din;
    end else begin : g_mid_b
      assign from_below = cell_q[k-1];
    end
    if (k == HALF - 1) begin : g_top
      assign from_above = din;
    end else begin : g_mid_a
      assign from_above = cell_q[k+1];
    end
    always_comb begin
      cell_d[k] = cell_q[k];
      if (en) cell_d[k] = dir_up ? from_below : from_above;
    end
  end

  assign dout = dir_up ? cell_q[HALF-1] : cell_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HALF; k++) cell_q[k] <= '0;
    end else begin
      for (int k = 0; k < HALF; k++) cell_q[k] <= cell_d[k];
    end
  end
endmodule

// File: rtl/fold_uni_buf.sv
module fold_uni_buf #(
  parameter int HALF = 4,
  parameter int W    = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] cell_q [HALF];
  logic [W-1:0] cell_d [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_cell
    if (k == 0) begin : g_bot
      assign cell_d[k] = en ? din : cell_q[k];
    end else begin : g_mid
      assign cell_d[k] = en ? cell_q[k-1] : cell_q[k];
    end
  end

  assign dout = cell_q[HALF-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HALF; k++) cell_q[k] <= '0;
    end else begin
      for (int k = 0; k < HALF; k++) cell_q[k] <= cell_d[k];
    end
  end
endmodule

// File: rtl/fold_twiddle_rom.sv
module fold_twiddle_rom #(
  parameter int FRAME_LEN = 8,
  parameter int HALF      = 4,
  parameter int IW        = 2,
  parameter int COEF_W    = 16,
  parameter int FRAC      = 14
) (
  input  logic                     [IW-1:0] idx,
  output logic signed [COEF_W-1:0]          coef
);
  localparam real PI_R = 3.14159265358979323846;

  logic signed [COEF_W-1:0] tbl [HALF];
  logic [IW-1:0] rev;

  for (genvar n = 0; n < HALF; n++) begin : g_tw
    localparam real ANG = (2.0 * real'(n) + 1.0) * PI_R / (2.0 * real'(FRAME_LEN));
    localparam int  CQ  = int'($floor($cos(ANG) * real'(1 << FRAC) + 0.5));
    assign tbl[n] = COEF_W'(CQ);
  end

  // differences leave with j ascending, which is n = HALF-1-j descending
  assign rev  = IW'(HALF - 1) - idx;
  assign coef = tbl[rev];
endmodule

// File: rtl/fold_butterfly_stage.sv
module fold_butterfly_stage
  import fold_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W:0]   out_data,
  output logic              out_is_sum
);
  localparam int HALF   = FRAME_LEN / 2;
  localparam int IW     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int OUT_W  = DATA_W + 1;
  localparam int PROD_W = OUT_W + COEF_W;
  localparam logic signed [PROD_W-1:0] RND = PROD_W'(1) <<< (COEF_FRAC - 1);

  half_e         half_q;
  logic [IW-1:0] idx_q;
  logic          primed_q;
  logic          dir_up_q;
  logic [DATA_W-1:0] pop_bi;
  logic [DATA_W-1:0] pop_uni;
  logic signed [COEF_W-1:0] coef;

  fold_seq_ctrl #(.HALF(HALF), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .half_q(half_q), .idx_q(idx_q), .primed_q(primed_q), .dir_up_q(dir_up_q)
  );

  fold_bidir_buf #(.HALF(HALF), .W(DATA_W)) u_bidir (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .dir_up(dir_up_q),
    .din(in_data), .dout(pop_bi)
  );

  fold_uni_buf #(.HALF(HALF), .W(DATA_W)) u_uni (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .din(pop_bi), .dout(pop_uni)
  );

  fold_twiddle_rom #(
    .FRAME_LEN(FRAME_LEN), .HALF(HALF), .IW(IW), .COEF_W(COEF_W), .FRAC(COEF_FRAC)
  ) u_rom (
    .idx(idx_q), .coef(coef)
  );

  // shared adder/subtractor: one select drives operand mux and operation
  logic                    add_sel;
  logic [DATA_W-1:0]       opa_raw, opb_raw;
  logic signed [OUT_W-1:0] opa, opb, as_res;
  logic signed [PROD_W-1:0] prod, rounded;
  logic [PROD_W-OUT_W:0]   hi_bits;
  logic signed [OUT_W-1:0] scaled;
  logic                    vld_d, sum_d;
  logic [OUT_W-1:0]        data_d;

  assign add_sel = (half_q == HALF_SECOND);
  assign opa_raw = add_sel ? pop_bi  : pop_uni;
  assign opb_raw = add_sel ? in_data : pop_bi;
  assign opa     = {opa_raw[DATA_W-1], opa_raw};
  assign opb     = {opb_raw[DATA_W-1], opb_raw};
  assign as_res  = add_sel ? (opa + opb) : (opa - opb);

  assign prod    = as_res * coef;
  assign rounded = (prod + RND) >>> COEF_FRAC;
  assign hi_bits = rounded[PROD_W-1:OUT_W-1];

  always_comb begin
    if ((&hi_bits) || !(|hi_bits)) scaled = rounded[OUT_W-1:0];
    else if (rounded[PROD_W-1])     scaled = {1'b1, {(OUT_W-1){1'b0}}};
    else                            scaled = {1'b0, {(OUT_W-1){1'b1}}};
  end

  always_comb begin
    vld_d  = in_valid && (add_sel || primed_q);
    sum_d  = out_is_sum;
    data_d = out_data;
    if (vld_d) begin
      sum_d  = add_sel;
      data_d = add_sel ? as_res : scaled;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_is_sum <= 1'b0;
      out_data   <= '0;
    end else begin
      out_valid  <= vld_d;
      out_is_sum <= sum_d;
      out_data   <= data_d;
    end
  end

  // magnitudes for the scaling check
  logic [OUT_W:0] res_ext, res_mag, out_ext, out_mag;
  assign res_ext = {as_res[OUT_W-1], as_res};
  assign res_mag = res_ext[OUT_W] ? -res_ext : res_ext;
  assign out_ext = {out_data[OUT_W-1], out_data};
  assign out_mag = out_ext[OUT_W] ? -out_ext : out_ext;

  // R6: a result needs an accepted word one clock earlier
  a_r6_out_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R3: twiddle scaling never grows the difference
  a_r3_diff_not_larger: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_sum) |-> (out_mag <= $past(res_mag) + 1'b1));
endmodule

// File: tb/fold_butterfly_stage_tb.sv
`timescale 1ns/1ps
module fold_butterfly_stage_tb;
  localparam int L = 8;
  localparam int H = L / 2;
  localparam real PI_R = 3.14159265358979323846;

  localparam logic signed [15:0] STIM [32] = '{
    16'sd120,   -16'sd45,   16'sd3000,  -16'sd7,    16'sd512,  16'sd9,     -16'sd1000, 16'sd77,
    -16'sd20000, 16'sd15000, 16'sd1,    -16'sd1,    16'sd250,  -16'sd30000, 16'sd12345, 16'sd0,
    16'sd32767, -16'sd32768, 16'sd100,  16'sd200,   -16'sd300, 16'sd400,    -16'sd500,  16'sd600,
    16'sd4096,  16'sd8192,   -16'sd4096, -16'sd8192, 16'sd31,  -16'sd31,    16'sd2222,  -16'sd3333
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [15:0] in_data;
  logic out_valid;
  logic [16:0] out_data;
  logic out_is_sum;

  int checks = 0;
  int failures = 0;
  int k_acc = 0;
  int frm [2][L];
  bit done = 0;

  always #5 clk = ~clk;

  fold_butterfly_stage #(.FRAME_LEN(L), .DATA_W(16), .COEF_W(16), .COEF_FRAC(14)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_is_sum(out_is_sum)
  );

  function automatic int coefq(int n);
    return int'($floor($cos((2.0 * real'(n) + 1.0) * PI_R / (2.0 * real'(L))) * 16384.0 + 0.5));
  endfunction

  task automatic check_out(bit ev, bit es, int ed, string tag);
    checks++;
    if (!ev) begin
      if (out_valid !== 1'b0) begin
        failures++;
        $display("FAIL %s out_valid actual=%0b expected=0", tag, out_valid);
      end
    end else if (out_valid !== 1'b1 || out_is_sum !== es || $signed(out_data) != ed) begin
      failures++;
      $display("FAIL %s valid/sum/data actual=%0b/%0b/%0d expected=1/%0b/%0d",
               tag, out_valid, out_is_sum, $signed(out_data), es, ed);
    end
  endtask

  // called at a falling edge; drives one word and checks the result one clock later
  task automatic send(int v, string tag);
    int p, f, ex;
    bit ev, es;
    longint pr;
    p = k_acc % L;
    f = k_acc / L;
    frm[f % 2][p] = v;
    ev = 0; es = 0; ex = 0;
    if (p >= H) begin
      ev = 1; es = 1;
      ex = frm[f % 2][H - 1 - (p - H)] + v;
    end else if (f >= 1) begin
      ev = 1; es = 0;
      pr = longint'(frm[(f - 1) % 2][H - 1 - p] - frm[(f - 1) % 2][H + p]) * coefq(H - 1 - p);
      ex = int'((pr + 8192) >>> 14);
    end
    k_acc++;
    in_valid = 1'b1;
    in_data  = v[15:0];
    @(negedge clk);
    check_out(ev, es, ex, tag);
  endtask

  task automatic idle(string tag);
    in_valid = 1'b0;
    in_data  = 16'h5a5a;
    @(negedge clk);
    check_out(0, 0, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    k_acc = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      failures++;
      $display("FAIL R1 during reset actual=%0b/%0d expected=0/0", out_valid, out_data);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      failures++;
      $display("FAIL R1 after release actual=%0b/%0d expected=0/0", out_valid, out_data);
    end
  endtask

  initial begin
    do_reset();
    // R7 R2 R3 R4 R5: four frames back to back from the table
    for (int i = 0; i < 32; i++) send(int'(STIM[i]), "R7 table");
    // R8: full-scale frame, then its differences
    for (int i = 0; i < H; i++) send(32767, "R8 full-scale");
    for (int i = 0; i < H; i++) send((i % 2 == 0) ? 32767 : -32768, "R8 full-scale");
    for (int i = 0; i < H; i++) send(-32768, "R8 diff");
    for (int i = 0; i < H; i++) send(32767, "R8 sum");
    // R6: gaps in the middle of a frame
    for (int i = 0; i < L; i++) begin
      send(1000 * i - 3500, "R6 gapped");
      idle("R6 idle");
      if (i == 5) idle("R6 idle");
    end
    for (int i = 0; i < H; i++) send(-7 * i, "R6 flush");
    // R4: reset mid-frame, first half silent again
    do_reset();
    for (int i = 0; i < L; i++) send(11 * i - 40, "R4 after reset");
    for (int i = 0; i < H; i++) send(5, "R3 after reset");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule